// File: doc/BRIEF.md
# Interrupt and Exception Vectoring Unit

This unit works next to the sequencer of a small processor core. Each time the sequencer signals an instruction boundary, the unit looks at the pending events. These are an exception raised by the instruction just finished, a software interrupt instruction, the non-maskable line and the maskable line. From these it decides whether a handler must be entered. When one is entered, the unit fixes the 8-bit vector. It computes the address of that vector's slot in the handler table and chooses which address goes on the stack as the resume point. It then asks the sequencer to push that address with the flags, and only in the following cycle does it signal that the handler may start.

Each exception carries a class. A fault resumes at the start of the faulting instruction, prefix bytes included, so the instruction can be re-executed. A trap resumes after the instruction. An abort is flagged as not restartable. Non-maskable requests always use vector 2. A maskable request is honoured only while the enable flag is set, and its vector comes from an external acknowledge handshake. In real mode each table slot is 4 bytes wide and in protected mode 8 bytes wide.

Top module: `intvec_dispatch`

## Requirements
- R1: Pending requests are evaluated only in a cycle where `boundary_i` is high and the unit is idle. Without a boundary strobe, neither `push_req_o` nor `ack_req_o` rises.
- R2: When several requests are present at one boundary, an exception wins over a software interrupt, which wins over NMI, which wins over the maskable line.
- R3: A fault (`exc_kind_i` = 2'b00) saves `cur_pc_i` as the return address. The vector is `exc_vec_i`.
- R4: A trap (`exc_kind_i` = 2'b01), a software interrupt, an NMI and a maskable interrupt all save `nxt_pc_i` as the return address. The value used is the one sampled at the boundary.
- R5: An abort (`exc_kind_i` = 2'b10 or 2'b11) saves `cur_pc_i` and sets `no_restart_o` along with the service. Every other kind of service clears `no_restart_o`.
- R6: An NMI is serviced with vector 2 whether or not `ien_i` is set.
- R7: A maskable request with `ien_i` low at the boundary is ignored. No acknowledge and no service follow.
- R8: An accepted maskable request raises `ack_req_o` two cycles after the boundary edge. `ack_req_o` stays high until `ack_valid_i` is seen, and the vector is taken from `ack_vec_i` in that cycle.
- R9: If `intr_i` is low in the cycle after the boundary that accepted it, the maskable request is dropped. `ack_req_o` never rises and no service follows.
- R10: The table address is `tbl_base_i + vector*4` when `prot_i` = 0 and `tbl_base_i + vector*8` when `prot_i` = 1. Both base and mode are sampled at the boundary, also for a maskable request that completes later.
- R11: After reset all outputs are zero. A service is a one-cycle `push_req_o` followed the next cycle by a one-cycle `svc_start_o`. The vector, table address, return address and abort flag change only together with `push_req_o` and then hold.
- R12: A boundary strobe that arrives while a service or an acknowledge is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| cur_pc_i | input | ADDR_W | Start address of the current instruction, prefixes included |
| nxt_pc_i | input | ADDR_W | Address of the following instruction |
| exc_req_i | input | 1 | Exception pending |
| exc_kind_i | input | 2 | Exception class: 00 fault, 01 trap, 10/11 abort |
| exc_vec_i | input | VEC_W | Exception vector |
| swi_req_i | input | 1 | Software interrupt pending |
| swi_vec_i | input | VEC_W | Software interrupt vector |
| nmi_i | input | 1 | Non-maskable request |
| intr_i | input | 1 | Maskable request line |
| ien_i | input | 1 | Interrupt enable flag |
| prot_i | input | 1 | 0 real mode, 1 protected mode |
| tbl_base_i | input | ADDR_W | Handler table base |
| ack_req_o | output | 1 | Acknowledge request for maskable vector |
| ack_valid_i | input | 1 | Acknowledge vector valid |
| ack_vec_i | input | VEC_W | Vector returned by acknowledge |
| push_req_o | output | 1 | Push return address and flags |
| svc_start_o | output | 1 | Handler may start |
| svc_vec_o | output | VEC_W | Chosen vector |
| svc_entry_o | output | ADDR_W | Table slot address |
| svc_ret_o | output | ADDR_W | Return address to save |
| no_restart_o | output | 1 | Service is an abort, no restart point |

## Verification
Each event class is tried on its own first. Fault, trap, abort, software interrupt, NMI and acknowledged maskable interrupt each show whether the right resume address and vector source are chosen. Stacked requests then show whether the priority order is kept. The pairs fault plus software plus NMI plus maskable, software plus NMI, and NMI plus enabled maskable each tell the winner apart from the next candidate. Masked, dropped and mid-acknowledge events separate "ignored" from "deferred" behaviour. The extreme vector 255 in both modes, together with a mode and base change during an acknowledge, separates the 4-byte scaling from the 8-byte scaling and shows whether the sampled mode or the live mode is used.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

   typedef enum logic [1:0] {
      EXC_FAULT     = 2'b00,
      EXC_TRAP      = 2'b01,
      EXC_ABORT     = 2'b10,
      EXC_ABORT_ALT = 2'b11
   } exc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_ACK   = 2'd2,
      ST_START = 2'd3
   } seq_state_e;

endpackage

// File: rtl/intvec_arbiter.sv
module intvec_arbiter
   import intvec_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2
)(
   input  logic             exc_req,
   input  logic [1:0]       exc_kind,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             swi_req,
   input  logic [VEC_W-1:0] swi_vec,
   input  logic             nmi,
   input  logic             intr,
   input  logic             ien,
   output logic             any,
   output logic [VEC_W-1:0] vec,
   output logic             take_cur,
   output logic             no_restart,
   output logic             need_ack
);

   localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

   exc_kind_e kind;
   assign kind = exc_kind_e'(exc_kind);

   always_comb begin
      any        = 1'b1;
      vec        = '0;
      take_cur   = 1'b0;
      no_restart = 1'b0;
      need_ack   = 1'b0;
      if (exc_req) begin
         vec = exc_vec;
         unique case (kind)
            EXC_FAULT: take_cur = 1'b1;
            EXC_TRAP:  take_cur = 1'b0;
            default: begin
               take_cur   = 1'b1;
               no_restart = 1'b1;
            end
         endcase
      end else if (swi_req) begin
         vec = swi_vec;
      end else if (nmi) begin
         vec = NMI_CODE;
      end else if (intr && ien) begin
         need_ack = 1'b1;
      end else begin
         any = 1'b0;
      end
   end

endmodule

// File: rtl/intvec_addr_gen.sv
module intvec_addr_gen #(
   parameter int ADDR_W       = 32,
   parameter int VEC_W        = 8,
   parameter int REAL_SHIFT   = 2,
   parameter int PROT_SHIFT   = 3,
   parameter bit BASE_ALIGNED = 1'b0
)(
   input  logic [ADDR_W-1:0] base,
   input  logic [VEC_W-1:0]  vec,
   input  logic              prot,
   output logic [ADDR_W-1:0] entry
);

   logic [ADDR_W-1:0] vec_ext;
   logic [ADDR_W-1:0] offset;

   assign vec_ext = ADDR_W'(vec);
   assign offset  = prot ? (vec_ext << PROT_SHIFT) : (vec_ext << REAL_SHIFT);

   generate
      if (BASE_ALIGNED) begin : g_merge
         assign entry = base | offset;
      end else begin : g_add
         assign entry = base + offset;
      end
   endgenerate

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
   import intvec_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int VEC_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              any,
   input  logic [VEC_W-1:0]  sel_vec,
   input  logic              take_cur,
   input  logic              no_restart,
   input  logic              need_ack,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] nxt_pc,
   input  logic              prot,
   input  logic [ADDR_W-1:0] base,
   input  logic              intr,
   input  logic              ack_valid,
   input  logic [VEC_W-1:0]  ack_vec,
   output logic              ack_req,
   output logic              push_req,
   output logic              svc_start,
   output logic [VEC_W-1:0]  vec_q,
   output logic [ADDR_W-1:0] ret_q,
   output logic              abort_q,
   output logic              prot_q,
   output logic [ADDR_W-1:0] base_q,
   output logic              idle,
   output logic              arm
);

   seq_state_e        state;
   logic [ADDR_W-1:0] pend_ret;
   logic [ADDR_W-1:0] pend_base;
   logic              pend_prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         push_req  <= 1'b0;
         svc_start <= 1'b0;
         vec_q     <= '0;
         ret_q     <= '0;
         abort_q   <= 1'b0;
         prot_q    <= 1'b0;
         base_q    <= '0;
         pend_ret  <= '0;
         pend_base <= '0;
         pend_prot <= 1'b0;
      end else begin
         push_req  <= 1'b0;
         svc_start <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (boundary && any) begin
                  if (need_ack) begin
                     pend_ret  <= nxt_pc;
                     pend_base <= base;
                     pend_prot <= prot;
                     state     <= ST_ARM;
                  end else begin
                     vec_q    <= sel_vec;
                     ret_q    <= take_cur ? cur_pc : nxt_pc;
                     abort_q  <= no_restart;
                     prot_q   <= prot;
                     base_q   <= base;
                     push_req <= 1'b1;
                     state    <= ST_START;
                  end
               end
            end
            ST_ARM: begin
               state <= intr ? ST_ACK : ST_IDLE;
            end
            ST_ACK: begin
               if (ack_valid) begin
                  vec_q    <= ack_vec;
                  ret_q    <= pend_ret;
                  abort_q  <= 1'b0;
                  prot_q   <= pend_prot;
                  base_q   <= pend_base;
                  push_req <= 1'b1;
                  state    <= ST_START;
               end
            end
            ST_START: begin
               svc_start <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ack_req = (state == ST_ACK);
   assign idle    = (state == ST_IDLE);
   assign arm     = (state == ST_ARM);

endmodule

// File: rtl/intvec_dispatch.sv
module intvec_dispatch #(
   parameter int ADDR_W       = 32,
   parameter int VEC_W        = 8,
   parameter int NMI_VEC      = 2,
   parameter int REAL_SHIFT   = 2,
   parameter int PROT_SHIFT   = 3,
   parameter bit BASE_ALIGNED = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic [ADDR_W-1:0] cur_pc_i,
   input  logic [ADDR_W-1:0] nxt_pc_i,
   input  logic              exc_req_i,
   input  logic [1:0]        exc_kind_i,
   input  logic [VEC_W-1:0]  exc_vec_i,
   input  logic              swi_req_i,
   input  logic [VEC_W-1:0]  swi_vec_i,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic              ien_i,
   input  logic              prot_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   output logic              ack_req_o,
   input  logic              ack_valid_i,
   input  logic [VEC_W-1:0]  ack_vec_i,
   output logic              push_req_o,
   output logic              svc_start_o,
   output logic [VEC_W-1:0]  svc_vec_o,
   output logic [ADDR_W-1:0] svc_entry_o,
   output logic [ADDR_W-1:0] svc_ret_o,
   output logic              no_restart_o
);

   localparam int SLOT_SPAN = VEC_W + PROT_SHIFT;

   generate
      if (VEC_W != 8) begin : g_bad_vec_w
         $error("intvec_dispatch: VEC_W must be 8");
      end
      if (NMI_VEC < 0 || NMI_VEC >= (1 << VEC_W)) begin : g_bad_nmi
         $error("intvec_dispatch: NMI_VEC outside vector space");
      end
      if (PROT_SHIFT <= REAL_SHIFT) begin : g_bad_shift
         $error("intvec_dispatch: protected slots must be wider than real slots");
      end
      if (ADDR_W < SLOT_SPAN) begin : g_bad_addr_w
         $error("intvec_dispatch: ADDR_W too narrow for the table span");
      end
   endgenerate

   logic             sel_any;
   logic [VEC_W-1:0] sel_vec;
   logic             sel_cur;
   logic             sel_abort;
   logic             sel_ack;
   logic             prot_q;
   logic [ADDR_W-1:0] base_q;
   logic             idle_w;
   logic             arm_w;

   intvec_arbiter #(
      .VEC_W   (VEC_W),
      .NMI_VEC (NMI_VEC)
   ) arb_i (
      .exc_req    (exc_req_i),
      .exc_kind   (exc_kind_i),
      .exc_vec    (exc_vec_i),
      .swi_req    (swi_req_i),
      .swi_vec    (swi_vec_i),
      .nmi        (nmi_i),
      .intr       (intr_i),
      .ien        (ien_i),
      .any        (sel_any),
      .vec        (sel_vec),
      .take_cur   (sel_cur),
      .no_restart (sel_abort),
      .need_ack   (sel_ack)
   );

   intvec_ctrl #(
      .ADDR_W (ADDR_W),
      .VEC_W  (VEC_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (boundary_i),
      .any        (sel_any),
      .sel_vec    (sel_vec),
      .take_cur   (sel_cur),
      .no_restart (sel_abort),
      .need_ack   (sel_ack),
      .cur_pc     (cur_pc_i),
      .nxt_pc     (nxt_pc_i),
      .prot       (prot_i),
      .base       (tbl_base_i),
      .intr       (intr_i),
      .ack_valid  (ack_valid_i),
      .ack_vec    (ack_vec_i),
      .ack_req    (ack_req_o),
      .push_req   (push_req_o),
      .svc_start  (svc_start_o),
      .vec_q      (svc_vec_o),
      .ret_q      (svc_ret_o),
      .abort_q    (no_restart_o),
      .prot_q     (prot_q),
      .base_q     (base_q),
      .idle       (idle_w),
      .arm        (arm_w)
   );

   intvec_addr_gen #(
      .ADDR_W       (ADDR_W),
      .VEC_W        (VEC_W),
      .REAL_SHIFT   (REAL_SHIFT),
      .PROT_SHIFT   (PROT_SHIFT),
      .BASE_ALIGNED (BASE_ALIGNED)
   ) addr_i (
      .base  (base_q),
      .vec   (svc_vec_o),
      .prot  (prot_q),
      .entry (svc_entry_o)
   );

endmodule

// File: rtl/intvec_dispatch_chk.sv
module intvec_dispatch_chk #(
   parameter int ADDR_W  = 32,
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              boundary_i,
   input logic [ADDR_W-1:0] cur_pc_i,
   input logic              exc_req_i,
   input logic [1:0]        exc_kind_i,
   input logic              swi_req_i,
   input logic              nmi_i,
   input logic              intr_i,
   input logic              ien_i,
   input logic              ack_req_o,
   input logic              ack_valid_i,
   input logic              push_req_o,
   input logic              svc_start_o,
   input logic [VEC_W-1:0]  svc_vec_o,
   input logic [ADDR_W-1:0] svc_ret_o,
   input logic              idle_i,
   input logic              arm_i
);

   assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && !boundary_i) |=> (!push_req_o && !ack_req_o));

   assert_fault_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && boundary_i && exc_req_i && exc_kind_i == 2'b00)
         |=> (push_req_o && svc_ret_o == $past(cur_pc_i)));

   assert_nmi_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && boundary_i && nmi_i && !exc_req_i && !swi_req_i)
         |=> (push_req_o && svc_vec_o == VEC_W'(NMI_VEC)));

   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && boundary_i && intr_i && !ien_i && !exc_req_i && !swi_req_i && !nmi_i)
         |=> (!push_req_o && !ack_req_o));

   assert_ack_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req_o && !ack_valid_i) |=> ack_req_o);

   assert_ack_from_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_req_o) |-> $past(arm_i));

   assert_intr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && !intr_i) |=> (!ack_req_o && !push_req_o));

   assert_push_then_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      push_req_o |=> svc_start_o);

   assert_start_after_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
      svc_start_o |-> $past(push_req_o));

   assert_ret_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !push_req_o |-> ($stable(svc_ret_o) && $stable(svc_vec_o)));

   assert_busy_no_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req_o) |-> !idle_i);

endmodule

bind intvec_dispatch intvec_dispatch_chk #(
   .ADDR_W  (ADDR_W),
   .VEC_W   (VEC_W),
   .NMI_VEC (NMI_VEC)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .boundary_i  (boundary_i),
   .cur_pc_i    (cur_pc_i),
   .exc_req_i   (exc_req_i),
   .exc_kind_i  (exc_kind_i),
   .swi_req_i   (swi_req_i),
   .nmi_i       (nmi_i),
   .intr_i      (intr_i),
   .ien_i       (ien_i),
   .ack_req_o   (ack_req_o),
   .ack_valid_i (ack_valid_i),
   .push_req_o  (push_req_o),
   .svc_start_o (svc_start_o),
   .svc_vec_o   (svc_vec_o),
   .svc_ret_o   (svc_ret_o),
   .idle_i      (idle_w),
   .arm_i       (arm_w)
);

// File: tb/intvec_dispatch_tb_top.sv
module intvec_dispatch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary_i = 1'b0;
   logic [31:0] cur_pc_i = '0;
   logic [31:0] nxt_pc_i = '0;
   logic        exc_req_i = 1'b0;
   logic [1:0]  exc_kind_i = 2'b00;
   logic [7:0]  exc_vec_i = '0;
   logic        swi_req_i = 1'b0;
   logic [7:0]  swi_vec_i = '0;
   logic        nmi_i = 1'b0;
   logic        intr_i = 1'b0;
   logic        ien_i = 1'b0;
   logic        prot_i = 1'b0;
   logic [31:0] tbl_base_i = '0;
   logic        ack_req_o;
   logic        ack_valid_i = 1'b0;
   logic [7:0]  ack_vec_i = '0;
   logic        push_req_o;
   logic        svc_start_o;
   logic [7:0]  svc_vec_o;
   logic [31:0] svc_entry_o;
   logic [31:0] svc_ret_o;
   logic        no_restart_o;

   always #10 clk = ~clk;

   intvec_dispatch dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .boundary_i   (boundary_i),
      .cur_pc_i     (cur_pc_i),
      .nxt_pc_i     (nxt_pc_i),
      .exc_req_i    (exc_req_i),
      .exc_kind_i   (exc_kind_i),
      .exc_vec_i    (exc_vec_i),
      .swi_req_i    (swi_req_i),
      .swi_vec_i    (swi_vec_i),
      .nmi_i        (nmi_i),
      .intr_i       (intr_i),
      .ien_i        (ien_i),
      .prot_i       (prot_i),
      .tbl_base_i   (tbl_base_i),
      .ack_req_o    (ack_req_o),
      .ack_valid_i  (ack_valid_i),
      .ack_vec_i    (ack_vec_i),
      .push_req_o   (push_req_o),
      .svc_start_o  (svc_start_o),
      .svc_vec_o    (svc_vec_o),
      .svc_entry_o  (svc_entry_o),
      .svc_ret_o    (svc_ret_o),
      .no_restart_o (no_restart_o)
   );

   typedef struct {
      logic [7:0]  vec;
      logic [31:0] entry;
      logic [31:0] ret;
      logic        abort;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   logic push_prev = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] slot(input logic [31:0] base, input logic [7:0] v, input logic prot);
      return base + (32'(v) * (prot ? 32'd8 : 32'd4));
   endfunction

   task automatic expect_svc(input logic [7:0] v, input logic [31:0] base, input logic prot,
                             input logic [31:0] ret, input logic abort, input string tag);
      exp_t e;
      e.vec = v; e.entry = slot(base, v, prot); e.ret = ret; e.abort = abort; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic clear_req();
      exc_req_i = 1'b0; swi_req_i = 1'b0; nmi_i = 1'b0;
   endtask

   task automatic strobe(input int settle);
      @(negedge clk);
      boundary_i = 1'b1;
      @(negedge clk);
      boundary_i = 1'b0;
      clear_req();
      repeat (settle) @(negedge clk);
   endtask

   // monitor: pops expected services as svc_start_o appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (svc_start_o) begin
            check(push_prev, "R11 push before start", 32'(push_prev), 32'd1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R12 unexpected service", 32'(svc_vec_o), 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(svc_vec_o == e.vec, {e.tag, " vector"}, 32'(svc_vec_o), 32'(e.vec));
               check(svc_entry_o == e.entry, {e.tag, " entry R10"}, svc_entry_o, e.entry);
               check(svc_ret_o == e.ret, {e.tag, " return"}, svc_ret_o, e.ret);
               check(no_restart_o == e.abort, {e.tag, " abort flag R5"}, 32'(no_restart_o), 32'(e.abort));
            end
         end
         push_prev <= push_req_o;
      end
   end

   initial begin
      #4000000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check({ack_req_o, push_req_o, svc_start_o, no_restart_o} == 4'b0, "R11 reset controls",
            32'({ack_req_o, push_req_o, svc_start_o, no_restart_o}), 32'd0);
      check(svc_vec_o == 8'd0 && svc_ret_o == 32'd0 && svc_entry_o == 32'd0, "R11 reset data",
            svc_ret_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 requests without a boundary strobe
      exc_req_i = 1'b1; exc_vec_i = 8'h0D; nmi_i = 1'b1; intr_i = 1'b1; ien_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!push_req_o && !ack_req_o, "R1 no strobe", 32'({push_req_o, ack_req_o}), 32'd0);
      end
      clear_req(); intr_i = 1'b0; ien_i = 1'b0;

      // R3 fault, real mode
      tbl_base_i = 32'h0000_1000; prot_i = 1'b0;
      cur_pc_i = 32'h0000_4000; nxt_pc_i = 32'h0000_4005;
      expect_svc(8'h0E, 32'h1000, 1'b0, 32'h4000, 1'b0, "R3 fault");
      exc_req_i = 1'b1; exc_kind_i = 2'b00; exc_vec_i = 8'h0E;
      strobe(3);

      // R4 trap, protected mode
      tbl_base_i = 32'h0002_0000; prot_i = 1'b1;
      cur_pc_i = 32'h0000_5000; nxt_pc_i = 32'h0000_5002;
      expect_svc(8'h03, 32'h2_0000, 1'b1, 32'h5002, 1'b0, "R4 trap");
      exc_req_i = 1'b1; exc_kind_i = 2'b01; exc_vec_i = 8'h03;
      strobe(3);

      // R5 abort, both encodings
      cur_pc_i = 32'h0000_6100; nxt_pc_i = 32'h0000_6104;
      expect_svc(8'h08, 32'h2_0000, 1'b1, 32'h6100, 1'b1, "R5 abort");
      exc_req_i = 1'b1; exc_kind_i = 2'b10; exc_vec_i = 8'h08;
      strobe(3);
      expect_svc(8'h12, 32'h2_0000, 1'b1, 32'h6100, 1'b1, "R5 abort alt");
      exc_req_i = 1'b1; exc_kind_i = 2'b11; exc_vec_i = 8'h12;
      strobe(3);

      // R4 software interrupt, real mode
      prot_i = 1'b0; tbl_base_i = 32'h0000_0400;
      cur_pc_i = 32'h0000_7000; nxt_pc_i = 32'h0000_7002;
      expect_svc(8'h80, 32'h400, 1'b0, 32'h7002, 1'b0, "R4 soft int");
      swi_req_i = 1'b1; swi_vec_i = 8'h80;
      strobe(3);
      check(svc_vec_o == 8'h80, "R11 outputs hold", 32'(svc_vec_o), 32'h80);

      // R2 everything at once: the fault wins
      ien_i = 1'b1; intr_i = 1'b1;
      expect_svc(8'h0D, 32'h400, 1'b0, 32'h7000, 1'b0, "R2 fault over all");
      exc_req_i = 1'b1; exc_kind_i = 2'b00; exc_vec_i = 8'h0D;
      swi_req_i = 1'b1; swi_vec_i = 8'h21; nmi_i = 1'b1;
      strobe(3);

      // R2 software over NMI and maskable
      expect_svc(8'h21, 32'h400, 1'b0, 32'h7002, 1'b0, "R2 soft over nmi");
      swi_req_i = 1'b1; swi_vec_i = 8'h21; nmi_i = 1'b1;
      strobe(3);

      // R6 NMI over enabled maskable, then NMI with enable clear
      expect_svc(8'h02, 32'h400, 1'b0, 32'h7002, 1'b0, "R6 nmi over intr");
      nmi_i = 1'b1;
      strobe(3);
      intr_i = 1'b0; ien_i = 1'b0;
      expect_svc(8'h02, 32'h400, 1'b0, 32'h7002, 1'b0, "R6 nmi masked flag");
      nmi_i = 1'b1;
      strobe(3);

      // R7 masked maskable request
      intr_i = 1'b1; ien_i = 1'b0;
      strobe(0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!ack_req_o && !push_req_o, "R7 masked", 32'({ack_req_o, push_req_o}), 32'd0);
      end
      intr_i = 1'b0;

      // R8 acknowledge flow, R10 sampled mode/base, R12 strobe while busy
      ien_i = 1'b1; intr_i = 1'b1; prot_i = 1'b1; tbl_base_i = 32'h0003_0000;
      cur_pc_i = 32'h0000_8000; nxt_pc_i = 32'h0000_8003;
      expect_svc(8'h41, 32'h3_0000, 1'b1, 32'h8003, 1'b0, "R8 ack vector");
      strobe(0);
      @(negedge clk);
      check(ack_req_o, "R8 ack raised", 32'(ack_req_o), 32'd1);
      boundary_i = 1'b1; exc_req_i = 1'b1; exc_kind_i = 2'b00; exc_vec_i = 8'h05;
      prot_i = 1'b0; tbl_base_i = 32'h0000_9000; nxt_pc_i = 32'h0000_AAAA;
      @(negedge clk);
      boundary_i = 1'b0; clear_req();
      check(ack_req_o && !push_req_o, "R12 strobe during ack", 32'({ack_req_o, push_req_o}), 32'b10);
      repeat (2) @(negedge clk);
      check(ack_req_o, "R8 ack held", 32'(ack_req_o), 32'd1);
      ack_valid_i = 1'b1; ack_vec_i = 8'h41;
      @(negedge clk);
      ack_valid_i = 1'b0; intr_i = 1'b0;
      check(push_req_o && !ack_req_o, "R8 ack complete", 32'({push_req_o, ack_req_o}), 32'b10);
      repeat (3) @(negedge clk);

      // R9 maskable line drops before the request is issued
      intr_i = 1'b1; ien_i = 1'b1;
      strobe(0);
      intr_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!ack_req_o && !push_req_o, "R9 dropped", 32'({ack_req_o, push_req_o}), 32'd0);
      end
      ien_i = 1'b0;

      // R10 top vector in both modes
      tbl_base_i = 32'h0010_0000; prot_i = 1'b0;
      cur_pc_i = 32'h0000_C000; nxt_pc_i = 32'h0000_C001;
      expect_svc(8'hFF, 32'h10_0000, 1'b0, 32'hC001, 1'b0, "R10 top real");
      swi_req_i = 1'b1; swi_vec_i = 8'hFF;
      strobe(3);
      prot_i = 1'b1;
      expect_svc(8'hFF, 32'h10_0000, 1'b1, 32'hC001, 1'b0, "R10 top prot");
      swi_req_i = 1'b1; swi_vec_i = 8'hFF;
      strobe(3);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11 all services seen", 32'(exp_q.size()), 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule